// File: doc/BRIEF.md
# Switch Bring-Up Sequencer

This block is a state machine that starts a switch chip after reset. It drives a simple internal register-write bus made of a one-cycle write strobe, an address and a data byte. After reset it captures a 2-bit boot-mode strap once. It then issues a fixed series of register writes that start the on-chip engines, in this order: the SRAM self-test, address-table aging, PHY auto-polling and the LED display. Between the writes it waits on handshake inputs from the engines it has started. When the series ends it raises a sticky `init_done` flag.

The boot-mode strap decides what happens between the self-test write and the wait for the self-test result:

- **Strap-only mode** goes straight on to the wait.
- **Both EEPROM modes** first wait for the EEPROM configuration download to finish.
- **CPU mode** waits for an external start bit.

An EEPROM download error cuts the series short. The sequencer skips the wait for the self-test result and the aging and polling writes, and goes directly to the LED-enable write.

The states are:

- `ST_SAMPLE`: captures the strap.
- `ST_KICK_SRAM`: issues the self-test write.
- `ST_WAIT_EE`: waits for the EEPROM download.
- `ST_WAIT_CPU`: waits for the start bit.
- `ST_WAIT_TEST`: waits for the self-test to complete.
- `ST_KICK_AGE`: issues the aging write.
- `ST_KICK_POLL`: issues the polling write.
- `ST_KICK_LED`: issues the LED-enable write.
- `ST_DONE`: the terminal state.

The transitions are:

- `ST_SAMPLE` always goes to `ST_KICK_SRAM`.
- `ST_KICK_SRAM` goes to `ST_WAIT_TEST`, `ST_WAIT_EE` or `ST_WAIT_CPU`, depending on the mode.
- `ST_WAIT_EE` goes to `ST_KICK_LED` on an error. Otherwise it goes to `ST_WAIT_TEST` when the download is done.
- `ST_WAIT_CPU` goes to `ST_WAIT_TEST` on the start bit.
- `ST_WAIT_TEST` goes to `ST_KICK_AGE` when the self-test is done.
- `ST_KICK_AGE`, `ST_KICK_POLL` and `ST_KICK_LED` each advance unconditionally to the next state.
- `ST_DONE` holds.

Top module: `swinit_seq`

## Requirements
- R1: While reset is asserted, `wr_en` and `init_done` are low.
- R2: The strap is captured on the first clock edge after reset is released. Later changes to the strap have no effect until the next reset.
- R3: On the cycle after the strap is captured, exactly one write is issued with address 0x0619 and data 0x01. Every write lasts one cycle. While `wr_en` is low, `wr_addr` and `wr_data` are zero.
- R4: Strap code 2'b11 (strap-only) goes directly to waiting for `sram_test_done`. In this mode `ee_load_done` and `ee_load_err` have no effect.
- R5: Strap codes 2'b10 (EEPROM) and 2'b00 (EEPROM speedup) wait for `ee_load_done` before they wait for `sram_test_done`.
- R6: In the EEPROM modes, `ee_load_err` sends the sequencer straight to the write to 0x000A with data 0x01. This write comes on the cycle after the error is sampled. The error wins over a simultaneous `ee_load_done`, and no aging or polling write is issued.
- R7: Strap code 2'b01 (CPU) waits for `cpu_start` after the self-test write. `ee_load_done` has no effect in this mode.
- R8: On the cycle after `sram_test_done` is sampled high in the test-wait state, the sequencer writes 0x01 to 0x0304. On the next two cycles it writes 0x08 to 0x0404 and then 0x01 to 0x000A.
- R9: `init_done` rises on the cycle after the LED-enable write. It stays high until reset, and no further writes are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_strap | input | 2 | Boot-mode strap code |
| sram_test_done | input | 1 | SRAM self-test complete |
| ee_load_done | input | 1 | EEPROM download complete |
| ee_load_err | input | 1 | EEPROM download failed |
| cpu_start | input | 1 | External start bit for CPU mode |
| wr_en | output | 1 | Register-write strobe, one cycle per write |
| wr_addr | output | 16 | Register address, valid while `wr_en` is high |
| wr_data | output | 8 | Register data, valid while `wr_en` is high |
| init_done | output | 1 | Bring-up complete, sticky |

## Verification
Every output is decoded from the state register, so each result appears one clock edge after the edge that samples its cause. The self-test write is due on cycle 1 after reset release. The aging write is due one cycle after the edge that samples `sram_test_done`, or two cycles after the handshake that ends an EEPROM or CPU wait. The LED write is due one cycle after an EEPROM error, and `init_done` one cycle after the LED write. The bench counts clock edges from reset release and logs each write with its cycle number at the falling edge. Each check compares that logged cycle with the exact cycle worked out from these delays.

// File: rtl/swinit_pkg.sv
package swinit_pkg;

    typedef enum logic [3:0] {
        ST_SAMPLE,
        ST_KICK_SRAM,
        ST_WAIT_EE,
        ST_WAIT_CPU,
        ST_WAIT_TEST,
        ST_KICK_AGE,
        ST_KICK_POLL,
        ST_KICK_LED,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        PATH_STRAP,
        PATH_EEPROM,
        PATH_CPU
    } boot_path_t;

    localparam logic [1:0] STRAP_ONLY   = 2'b11;
    localparam logic [1:0] STRAP_EEPROM = 2'b10;
    localparam logic [1:0] STRAP_CPU    = 2'b01;
    localparam logic [1:0] STRAP_EE_FST = 2'b00;

endpackage

// File: rtl/swinit_path_dec.sv
module swinit_path_dec
    import swinit_pkg::*;
(
    input  logic [1:0] strap_q,
    output boot_path_t path
);
    always_comb begin
        unique case (strap_q)
            STRAP_ONLY:   path = PATH_STRAP;
            STRAP_CPU:    path = PATH_CPU;
            STRAP_EEPROM: path = PATH_EEPROM;
            default:      path = PATH_EEPROM;
        endcase
    end
endmodule

// File: rtl/swinit_cmd_rom.sv
module swinit_cmd_rom
    import swinit_pkg::*;
#(
    parameter int            ADDR_W    = 16,
    parameter int            DATA_W    = 8,
    parameter logic [ADDR_W-1:0] A_SRAM = 16'h0619,
    parameter logic [ADDR_W-1:0] A_AGE  = 16'h0304,
    parameter logic [ADDR_W-1:0] A_POLL = 16'h0404,
    parameter logic [ADDR_W-1:0] A_LED  = 16'h000A,
    parameter logic [DATA_W-1:0] D_SRAM = 8'h01,
    parameter logic [DATA_W-1:0] D_AGE  = 8'h01,
    parameter logic [DATA_W-1:0] D_POLL = 8'h08,
    parameter logic [DATA_W-1:0] D_LED  = 8'h01
) (
    input  seq_state_t        state,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    always_comb begin
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        unique case (state)
            ST_KICK_SRAM: begin wr_en = 1'b1; wr_addr = A_SRAM; wr_data = D_SRAM; end
            ST_KICK_AGE:  begin wr_en = 1'b1; wr_addr = A_AGE;  wr_data = D_AGE;  end
            ST_KICK_POLL: begin wr_en = 1'b1; wr_addr = A_POLL; wr_data = D_POLL; end
            ST_KICK_LED:  begin wr_en = 1'b1; wr_addr = A_LED;  wr_data = D_LED;  end
            default: ;
        endcase
    end
endmodule

// File: rtl/swinit_fsm.sv
module swinit_fsm
    import swinit_pkg::*;
#(
    parameter int STRAP_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] boot_strap,
    input  boot_path_t         path,
    input  logic               sram_test_done,
    input  logic               ee_load_done,
    input  logic               ee_load_err,
    input  logic               cpu_start,
    output logic [STRAP_W-1:0] strap_q,
    output seq_state_t         state,
    output logic               init_done
);
    seq_state_t state_nx;

    // state register and strap capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_SAMPLE;
            strap_q <= '1;
        end else begin
            state <= state_nx;
            if (state == ST_SAMPLE)
                strap_q <= boot_strap;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SAMPLE:    state_nx = ST_KICK_SRAM;
            ST_KICK_SRAM: begin
                unique case (path)
                    PATH_EEPROM: state_nx = ST_WAIT_EE;
                    PATH_CPU:    state_nx = ST_WAIT_CPU;
                    default:     state_nx = ST_WAIT_TEST;
                endcase
            end
            ST_WAIT_EE: begin
                if (ee_load_err)       state_nx = ST_KICK_LED;
                else if (ee_load_done) state_nx = ST_WAIT_TEST;
            end
            ST_WAIT_CPU:  if (cpu_start)      state_nx = ST_WAIT_TEST;
            ST_WAIT_TEST: if (sram_test_done) state_nx = ST_KICK_AGE;
            ST_KICK_AGE:  state_nx = ST_KICK_POLL;
            ST_KICK_POLL: state_nx = ST_KICK_LED;
            ST_KICK_LED:  state_nx = ST_DONE;
            ST_DONE:      state_nx = ST_DONE;
            default:      state_nx = ST_SAMPLE;
        endcase
    end

    // output process
    always_comb begin
        init_done = (state == ST_DONE);
    end
endmodule

// File: rtl/swinit_seq.sv
module swinit_seq
    import swinit_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        boot_strap,
    input  logic              sram_test_done,
    input  logic              ee_load_done,
    input  logic              ee_load_err,
    input  logic              cpu_start,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              init_done
);
    logic [1:0] strap_q;
    boot_path_t path;
    seq_state_t state;

    swinit_fsm #(.STRAP_W(2)) u_fsm (
        .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap), .path(path),
        .sram_test_done(sram_test_done), .ee_load_done(ee_load_done),
        .ee_load_err(ee_load_err), .cpu_start(cpu_start),
        .strap_q(strap_q), .state(state), .init_done(init_done)
    );

    swinit_path_dec u_dec (.strap_q(strap_q), .path(path));

    swinit_cmd_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
        .state(state), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );
endmodule

// File: rtl/swinit_seq_chk.sv
module swinit_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              init_done
);
    always @(posedge clk) begin
        if (!rst_n) begin
            p_quiet_in_reset_r1: assert (!wr_en && !init_done);
        end
    end

    p_idle_bus_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (wr_addr == '0 && wr_data == '0));

    p_age_then_poll_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 16'h0304) |=> (wr_en && wr_addr == 16'h0404 && wr_data == 8'h08));

    p_poll_then_led_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 16'h0404) |=> (wr_en && wr_addr == 16'h000A && wr_data == 8'h01));

    p_led_then_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 16'h000A) |=> init_done);

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_no_write_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> !wr_en);
endmodule

bind swinit_seq swinit_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .init_done(init_done)
);

// File: tb/tb_swinit_seq.sv
module tb_swinit_seq;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  boot_strap = 2'b11;
    logic        sram_test_done = 1'b0;
    logic        ee_load_done = 1'b0;
    logic        ee_load_err = 1'b0;
    logic        cpu_start = 1'b0;
    logic        wr_en;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;
    logic        init_done;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int log_n = 0;
    int done_cyc = -1;
    logic [15:0] log_addr [16];
    logic [7:0]  log_data [16];
    int          log_cyc  [16];
    bit finished = 0;

    swinit_seq dut (
        .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap),
        .sram_test_done(sram_test_done), .ee_load_done(ee_load_done),
        .ee_load_err(ee_load_err), .cpu_start(cpu_start),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .init_done(init_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en && log_n < 16) begin
                log_addr[log_n] = wr_addr;
                log_data[log_n] = wr_data;
                log_cyc[log_n]  = cyc;
                log_n = log_n + 1;
            end
            if (init_done && done_cyc < 0) done_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic chk_wr(input int idx, input logic [15:0] a, input logic [7:0] d,
                          input int c, input string tag);
        chk(log_n > idx, {tag, " write count"}, log_n, idx + 1);
        if (log_n > idx) begin
            chk(log_addr[idx] == a, {tag, " addr"}, int'(log_addr[idx]), int'(a));
            chk(log_data[idx] == d, {tag, " data"}, int'(log_data[idx]), int'(d));
            chk(log_cyc[idx] == c, {tag, " cycle"}, log_cyc[idx], c);
        end
    endtask

    task automatic start(input logic [1:0] s);
        rst_n = 1'b0;
        boot_strap = s;
        sram_test_done = 0; ee_load_done = 0; ee_load_err = 0; cpu_start = 0;
        repeat (3) @(negedge clk);
        log_n = 0; done_cyc = -1;
        chk(!wr_en && !init_done, "R1 outputs in reset", {wr_en, init_done}, 0);
        rst_n = 1'b1;
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic tail_ok(input int led_c, input string tag);
        chk(done_cyc == led_c + 1, {tag, " R9 done cycle"}, done_cyc, led_c + 1);
    endtask

    task automatic t_strap_fast();
        start(2'b11);
        sram_test_done = 1; ee_load_err = 1; ee_load_done = 0;
        wait_to(12);
        chk(log_n == 4, "R4 strap write count", log_n, 4);
        chk_wr(0, 16'h0619, 8'h01, 1, "R3 sram kick");
        chk_wr(1, 16'h0304, 8'h01, 3, "R8 age");
        chk_wr(2, 16'h0404, 8'h08, 4, "R8 poll");
        chk_wr(3, 16'h000A, 8'h01, 5, "R8 led");
        tail_ok(5, "strap");
    endtask

    task automatic t_strap_slow();
        start(2'b11);
        wait_to(10);
        chk(log_n == 1 && done_cyc < 0, "R4 holds for self-test", log_n, 1);
        sram_test_done = 1;
        wait_to(16);
        chk_wr(1, 16'h0304, 8'h01, 11, "R8 age after late test");
        chk_wr(3, 16'h000A, 8'h01, 13, "R8 led after late test");
    endtask

    task automatic t_eeprom(input logic [1:0] s, input int go);
        start(s);
        sram_test_done = 1;
        wait_to(1);
        boot_strap = 2'b11;
        wait_to(go);
        chk(log_n == 1, "R5 waits for EEPROM", log_n, 1);
        ee_load_done = 1;
        wait_to(go + 8);
        chk_wr(0, 16'h0619, 8'h01, 1, "R3 sram kick ee");
        chk_wr(1, 16'h0304, 8'h01, go + 2, "R5 age after load");
        chk_wr(3, 16'h000A, 8'h01, go + 4, "R5 led after load");
        tail_ok(go + 4, "R2 eeprom");
    endtask

    task automatic t_ee_error();
        start(2'b10);
        wait_to(6);
        ee_load_err = 1; ee_load_done = 1;
        wait_to(14);
        chk(log_n == 2, "R6 only two writes", log_n, 2);
        chk_wr(1, 16'h000A, 8'h01, 7, "R6 led on error");
        tail_ok(7, "R6");
    endtask

    task automatic t_cpu();
        start(2'b01);
        sram_test_done = 1; ee_load_done = 1;
        wait_to(9);
        chk(log_n == 1, "R7 waits for start", log_n, 1);
        cpu_start = 1;
        wait_to(17);
        chk_wr(1, 16'h0304, 8'h01, 11, "R7 age after start");
        chk_wr(2, 16'h0404, 8'h08, 12, "R7 poll");
        tail_ok(13, "R7");
    endtask

    task automatic t_sticky();
        start(2'b11);
        sram_test_done = 1;
        wait_to(8);
        sram_test_done = 0; ee_load_err = 1; cpu_start = 1;
        boot_strap = 2'b01;
        wait_to(30);
        chk(init_done == 1'b1, "R9 done sticky", init_done, 1);
        chk(log_n == 4, "R9 no writes after done", log_n, 4);
        chk(!wr_en && wr_addr == 0 && wr_data == 0, "R3 idle bus zero",
            {wr_addr, wr_data}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_strap_fast();
        t_strap_slow();
        t_eeprom(2'b10, 8);
        t_eeprom(2'b00, 5);
        t_ee_error();
        t_cpu();
        t_sticky();
        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule